// File: doc/BRIEF.md
# Power-of-Two Scan Clock Divider

This block derives a scan test clock from the system clock. A free-running binary counter advances on every system clock edge. A one-hot divisor word selects one counter tap, and that tap becomes the scan clock. The only available ratios are powers of two from 2 to 128. The scan clock leaves the block as a registered signal, so it carries no glitches from the select logic.

When streaming mode is active and the outgoing-data buffer reports empty, the block holds the scan clock low. This stops the target from shifting stale data. The hold can only begin or end while the clock is low, so every high phase that starts also runs to its full length. A one-cycle strobe marks each rising edge of the scan clock, so logic that runs on the system clock can act in step with the scan clock without a second clock domain.

Top module: `scd_clk_div`

## Requirements
- R1: While reset is asserted, and in the first cycle after release, the scan clock and the rise strobe are low and the tap counter is zero.
- R2: With only divisor bit k set (1 ≤ k ≤ 7), the scan clock has a period of 2^k system cycles and 50% duty. Its first rise comes at system edge 2^(k-1) after reset, counting the first edge as edge 1.
- R3: Divisor bit 0 and bits 8 to 15 have no effect on the output.
- R4: When none of divisor bits 1 to 7 is set, the scan clock is low from the next cycle on and no strobe is produced.
- R5: When several of divisor bits 1 to 7 are set, the lowest set bit alone selects the ratio.
- R6: While the streaming-mode bit and the buffer-empty flag are both 1, a low scan clock stays low.
- R7: A high phase that has started always lasts its full 2^(k-1) cycles, even if the hold condition arises during it. After the hold is released, the next rise falls on a counter-aligned rising point, so no shortened high pulse appears.
- R8: The rise strobe is high for exactly the first system cycle in which the scan clock is high, and at no other time.
- R9: With the streaming-mode bit at 0, the buffer-empty flag has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | 16 | One-hot divisor word; only bits 1 to 7 are honoured |
| stream_mode_i | input | 1 | Enables gating on an empty buffer |
| buf_empty_i | input | 1 | Outgoing-data buffer is empty |
| scan_clk_o | output | 1 | Divided scan clock, registered |
| rise_stb_o | output | 1 | One-cycle pulse in the first high cycle of the scan clock |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor word with taps 1 to 7, which gives a 7-bit counter. This covers every legal ratio, the divisor bits that must be ignored at both ends of the word, and the counter wrap at 128 cycles, where all the periods realign. The bench changes the divisor while the clock is running, and it asserts the hold in the middle of a high phase and releases it between rising points. These cases show that gating never shortens a pulse and that resumption stays in phase with the counter.

// File: rtl/scd_pkg.sv
`timescale 1ns/1ps
package scd_pkg;
   localparam int unsigned SCD_DIV_W  = 16;
   localparam int unsigned SCD_TAP_LO = 1;
   localparam int unsigned SCD_TAP_HI = 7;

   typedef struct packed {
      logic clk;
      logic stb;
   } scd_out_t;
endpackage

// File: rtl/scd_free_counter.sv
`timescale 1ns/1ps
module scd_free_counter #(
   parameter int unsigned W = 7
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   output logic [W-1:0] cnt_o,
   output logic [W-1:0] cnt_nx_o
);
   logic [W-1:0] cnt_q;

   assign cnt_nx_o = cnt_q + {{(W-1){1'b0}}, 1'b1};
   assign cnt_o    = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_nx_o;
   end
endmodule

// File: rtl/scd_tap_decode.sv
`timescale 1ns/1ps
module scd_tap_decode #(
   parameter int unsigned TAP_LO = 1,
   parameter int unsigned TAP_HI = 7
) (
   input  logic [TAP_HI:TAP_LO] field_i,
   output logic [TAP_HI-1:0]    pick_o
);
   logic [TAP_HI:TAP_LO] seen;

   generate
      for (genvar z = 1; z < TAP_LO; z++) begin : g_unused_tap
         assign pick_o[z-1] = 1'b0;
      end
      for (genvar g = TAP_LO; g <= TAP_HI; g++) begin : g_tap
         if (g == TAP_LO) begin : g_first
            assign seen[g]     = field_i[g];
            assign pick_o[g-1] = field_i[g];
         end else begin : g_rest
            assign seen[g]     = seen[g-1] | field_i[g];
            assign pick_o[g-1] = field_i[g] & ~seen[g-1];
         end
      end
   endgenerate
endmodule

// File: rtl/scd_gate_ctl.sv
`timescale 1ns/1ps
module scd_gate_ctl
   import scd_pkg::*;
#(
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] pick_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cnt_nx_i,
   input  logic             hold_i,
   output scd_out_t         out_o
);
   logic     tap_nx, tap_now, tap_ok, rise_pt;
   scd_out_t q, d;

   assign tap_ok  = |pick_i;
   assign tap_nx  = |(pick_i & cnt_nx_i);
   assign tap_now = |(pick_i & cnt_i);
   assign rise_pt = tap_nx & ~tap_now;

   always_comb begin
      d.clk = tap_ok & (q.clk ? tap_nx : (rise_pt & ~hold_i));
      d.stb = d.clk & ~q.clk;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d;
   end

   assign out_o = q;
endmodule

// File: rtl/scd_clk_div.sv
`timescale 1ns/1ps
module scd_clk_div
   import scd_pkg::*;
#(
   parameter int unsigned DIV_W  = SCD_DIV_W,
   parameter int unsigned TAP_LO = SCD_TAP_LO,
   parameter int unsigned TAP_HI = SCD_TAP_HI
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [DIV_W-1:0] div_i,
   input  logic             stream_mode_i,
   input  logic             buf_empty_i,
   output logic             scan_clk_o,
   output logic             rise_stb_o
);
   localparam int unsigned CNT_W = TAP_HI;

   generate
      if (TAP_LO < 1) begin : g_bad_lo
         $error("scd_clk_div: TAP_LO must be at least 1");
      end
      if (TAP_HI < TAP_LO) begin : g_bad_order
         $error("scd_clk_div: TAP_HI must not be below TAP_LO");
      end
      if (TAP_HI >= DIV_W) begin : g_bad_width
         $error("scd_clk_div: TAP_HI must lie inside the divisor word");
      end
   endgenerate

   logic [DIV_W-1:0] unused_div;
   logic [CNT_W-1:0] cnt, cnt_nx, pick;
   scd_out_t         gout;

   assign unused_div = div_i;

   scd_free_counter #(.W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cnt_o   (cnt),
      .cnt_nx_o(cnt_nx)
   );

   scd_tap_decode #(.TAP_LO(TAP_LO), .TAP_HI(TAP_HI)) u_dec (
      .field_i(div_i[TAP_HI:TAP_LO]),
      .pick_o (pick)
   );

   scd_gate_ctl #(.CNT_W(CNT_W)) u_gate (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pick_i  (pick),
      .cnt_i   (cnt),
      .cnt_nx_i(cnt_nx),
      .hold_i  (stream_mode_i & buf_empty_i),
      .out_o   (gout)
   );

   assign scan_clk_o = gout.clk;
   assign rise_stb_o = gout.stb;
endmodule

// File: rtl/scd_chk.sv
`timescale 1ns/1ps
module scd_chk #(
   parameter int unsigned DIV_W  = 16,
   parameter int unsigned TAP_LO = 1,
   parameter int unsigned TAP_HI = 7
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [DIV_W-1:0] div_i,
   input logic             stream_mode_i,
   input logic             buf_empty_i,
   input logic             scan_clk_o,
   input logic             rise_stb_o
);
   a_r4_no_tap_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_i[TAP_HI:TAP_LO] == '0) |=> !scan_clk_o);

   a_r6_hold_keeps_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!scan_clk_o && stream_mode_i && buf_empty_i) |=> !scan_clk_o);

   a_r8_stb_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(scan_clk_o) |-> rise_stb_o);

   a_r8_stb_only_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_stb_o |-> (scan_clk_o && !$past(scan_clk_o)));

   a_r8_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_stb_o |=> !rise_stb_o);
endmodule

bind scd_clk_div scd_chk #(.DIV_W(DIV_W), .TAP_LO(TAP_LO), .TAP_HI(TAP_HI)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .div_i        (div_i),
   .stream_mode_i(stream_mode_i),
   .buf_empty_i  (buf_empty_i),
   .scan_clk_o   (scan_clk_o),
   .rise_stb_o   (rise_stb_o)
);

// File: tb/scd_clk_div_tb_top.sv
`timescale 1ns/1ps
module scd_clk_div_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] div = 16'h0000;
   logic        smode = 1'b0;
   logic        empty = 1'b0;
   logic        sclk, stb;

   int    n_chk = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   bit    cmp_on = 1'b0;
   bit    done = 1'b0;

   int m_n, m_k, m_per, m_ph;
   bit m_clk, m_stb, m_nt;

   always #5 clk = ~clk;

   scd_clk_div dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .div_i        (div),
      .stream_mode_i(smode),
      .buf_empty_i  (empty),
      .scan_clk_o   (sclk),
      .rise_stb_o   (stb)
   );

   // behavioural reference: a count of edges since reset, and phase arithmetic
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_n = 0; m_clk = 1'b0; m_stb = 1'b0;
      end else begin
         m_n = (m_n + 1) % 128;
         m_k = 0;
         for (int b = 7; b >= 1; b--) if (div[b]) m_k = b;
         if (m_k == 0) m_nt = 1'b0;
         else begin
            m_per = 1 << m_k;
            m_ph  = m_n % m_per;
            if (m_clk) m_nt = (m_ph >= m_per / 2);
            else       m_nt = (m_ph == m_per / 2) && !(smode && empty);
         end
         m_stb = !m_clk && m_nt;
         m_clk = m_nt;
      end
   end

   task automatic check(string req, string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && rst_n && !done) begin
         check(cur_req, "scan clock", sclk, m_clk);
         check(cur_req, "rise strobe", stb, m_stb);
      end
   end

   task automatic run(int cyc);
      repeat (cyc) @(negedge clk);
   endtask

   // count strobes over a window, sampled away from the edge
   task automatic count_stb(int cyc, output int cnt);
      cnt = 0;
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         if (stb) cnt++;
      end
   endtask

   initial begin
      int c;
      repeat (3) @(negedge clk);
      check("R1", "scan clock in reset", sclk, 1'b0);
      check("R1", "strobe in reset", stb, 1'b0);
      div = 16'h0002;
      rst_n = 1'b1;
      check("R1", "scan clock after release", sclk, 1'b0);
      cmp_on = 1'b1;

      // R2: every legal ratio, changed while running
      cur_req = "R2";
      for (int k = 1; k <= 7; k++) begin
         div = 16'(1 << k);
         run(300);
      end
      div = 16'h0008;
      run(8);
      count_stb(64, c);
      check("R2", "strobes per 64 cycles at /8", c == 8, 1'b1);

      // R3: ignored bits at both ends of the word
      cur_req = "R3";
      div = 16'hFF11;
      run(100);
      count_stb(64, c);
      check("R3", "strobes per 64 cycles at /16 with ignored bits", c == 4, 1'b1);
      div = 16'hFF01;
      run(5);
      count_stb(64, c);
      check("R3", "only ignored bits set gives no strobe", c == 0, 1'b1);

      // R4: no honoured bit
      cur_req = "R4";
      div = 16'h0004;
      run(20);
      div = 16'h0000;
      run(3);
      check("R4", "scan clock with empty divisor", sclk, 1'b0);
      run(60);

      // R5: lowest set bit wins
      cur_req = "R5";
      div = 16'h0054;
      run(40);
      count_stb(64, c);
      check("R5", "strobes per 64 cycles with bits 2,4,6", c == 16, 1'b1);

      // R6/R7: hold toggled at awkward points
      cur_req = "R6";
      div = 16'h0020;
      smode = 1'b1;
      empty = 1'b1;
      run(70);
      check("R6", "scan clock under hold", sclk, 1'b0);
      cur_req = "R7";
      for (int i = 0; i < 20; i++) begin
         empty = ~empty;
         run(13 + i);
      end
      div = 16'h0004;
      for (int i = 0; i < 20; i++) begin
         empty = ~empty;
         run(3 + (i % 4));
      end
      empty = 1'b0;
      run(50);

      // R9: empty flag without streaming mode
      cur_req = "R9";
      smode = 1'b0;
      empty = 1'b1;
      div = 16'h0008;
      run(16);
      count_stb(64, c);
      check("R9", "strobes at /8 with empty but mode off", c == 8, 1'b1);

      // R8: strobe placement across a final mixed sweep
      cur_req = "R8";
      smode = 1'b1;
      for (int i = 0; i < 30; i++) begin
         empty = (i % 3 == 0);
         div = 16'(1 << (1 + (i % 7)));
         run(11);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule